// File: doc/BRIEF.md
# Serial-addressed multi-channel DAC code register

This block is the digital front end of a multi-channel digital-to-analog converter. A host sends 14-bit command words one bit at a time on a serial clock and data pair. A load strobe then copies the word into one channel's 10-bit code latch. The first four bits of a word carry the channel number and the remaining ten carry the code. One strap input chooses whether the code field arrives least-significant or most-significant bit first. The channel number is always sent least-significant bit first.

The serial clock, data and load inputs are asynchronous to the block. Each is passed through a synchronizer into a faster system clock, and their edges are detected in that domain. The bit that falls off the end of the shift register is driven on a cascade output, so a second device can be chained behind this one on the same clock and load lines. An active-low reset clears every channel code to zero, which is the low end of the output range, and also clears the shift register. The channel count is a build option of 8 or 10.

Top module: `sdac_front`

## Requirements
- R1: On each rising edge of `sclk`, one bit of `sdi` enters the 14-bit shift register. The first bit of a word ends up as bit 0 of the address field.
- R2: When the 4-bit address field holds a value A from 1 to NUM_CH, a load strobe writes the code field into channel A. Channel A is bits [(A-1)*10 +: 10] of `chan_codes`. No other channel changes.
- R3: Address 0 and every address above NUM_CH leave all channel codes unchanged when loaded.
- R4: With `order_lsb` = 1, the first code bit received is code bit 0. With `order_lsb` = 0, the first code bit received is code bit 9. Address bit order is the same in both cases.
- R5: The load input is level-sensitive. One transfer happens on the rising level of `ld`. Channel codes change at no other time, and a single strobe changes at most one channel.
- R6: Rising `sclk` edges that occur while `ld` is high are ignored, so the shift register holds its contents for the whole strobe.
- R7: `sdo` shows bit 0 of the shift register. It changes only when a bit is shifted in, so after a complete word it equals the word's first bit.
- R8: While `rst_n` is low, every channel code and the shift register are zero. A reset that arrives partway through a word discards the bits received so far.
- R9: NUM_CH must be 8 or 10. In the 8-channel build, addresses 9 and 10 are reserved and update nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. Must be several times faster than `sclk`. |
| rst_n | input | 1 | Asynchronous active-low reset. Clears the codes and the shift register. |
| sclk | input | 1 | Serial shift clock. Sampled on its rising edge. |
| sdi | input | 1 | Serial command data. |
| ld | input | 1 | Level-sensitive load strobe. |
| order_lsb | input | 1 | Code-field bit order: 1 = LSB first, 0 = MSB first. |
| sdo | output | 1 | Cascade output. Carries the far-end bit of the shift register. |
| chan_codes | output | NUM_CH*10 | Packed 10-bit codes. Channel 1 is in the lowest bits. |

## Verification
Two events can meet in one system cycle: a shift edge from `sclk` and the rising level of `ld`. That is the case the block must keep apart from the load. The bench raises `ld` after a full word and, while it is still high, toggles `sclk` with ones on `sdi`. It then strobes again with no new bits. Both strobes must leave the original code in the addressed channel and the original first bit on `sdo`. The checker also proves, on every cycle, that the shift register never moves while the synchronized load level is high.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   localparam int ADDR_W_DEF  = 4;
   localparam int DATA_W_DEF  = 10;
   localparam int NUM_CH_DEF  = 10;
   localparam int SYNC_STAGES = 2;

   // indices of the synchronised input bus
   localparam int IDX_SCLK = 0;
   localparam int IDX_SDI  = 1;
   localparam int IDX_LD   = 2;
   localparam int SYNC_W   = 3;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("sdac_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
   parameter int FRAME_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               din,
   output logic [FRAME_W-1:0] shreg,
   output logic               sdo
);
   // new bits enter at the top; the first bit of a word ends up in bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shreg <= '0;
      else if (shift_en) shreg <= {din, shreg[FRAME_W-1:1]};
   end

   assign sdo = shreg[0];
endmodule

// File: rtl/sdac_decode.sv
module sdac_decode #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 10,
   parameter int NUM_CH = 10,
   localparam int FRAME_W = ADDR_W + DATA_W
) (
   input  logic [FRAME_W-1:0] frame,
   input  logic               order_lsb,
   output logic [NUM_CH-1:0]  sel,
   output logic [DATA_W-1:0]  code
);
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] raw;
   logic [DATA_W-1:0] rev;

   assign addr = frame[ADDR_W-1:0];
   assign raw  = frame[FRAME_W-1:ADDR_W];

   for (genvar g = 0; g < DATA_W; g++) begin : g_rev
      assign rev[g] = raw[DATA_W-1-g];
   end

   assign code = order_lsb ? raw : rev;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
      assign sel[g] = (addr == ADDR_W'(g + 1));
   end
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
   parameter int NUM_CH = sdac_pkg::NUM_CH_DEF,
   parameter int ADDR_W = sdac_pkg::ADDR_W_DEF,
   parameter int DATA_W = sdac_pkg::DATA_W_DEF,
   parameter int SYNC_N = sdac_pkg::SYNC_STAGES
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sclk,
   input  logic                     sdi,
   input  logic                     ld,
   input  logic                     order_lsb,
   output logic                     sdo,
   output logic [NUM_CH*DATA_W-1:0] chan_codes
);
   import sdac_pkg::*;

   localparam int FRAME_W = ADDR_W + DATA_W;

   if (NUM_CH != 8 && NUM_CH != 10) begin : g_bad_ch
      $error("sdac_front: NUM_CH must be 8 or 10");
   end
   if ((1 << ADDR_W) <= NUM_CH) begin : g_bad_addr
      $error("sdac_front: ADDR_W too narrow for NUM_CH");
   end

   logic [SYNC_W-1:0]  raw_in, syn;
   logic               s_sclk, s_sdi, s_ld;
   logic               prev_sclk, prev_ld;
   logic               sclk_rise, ld_rise, shift_en;
   logic [FRAME_W-1:0] shreg;
   logic [NUM_CH-1:0]  sel;
   logic [DATA_W-1:0]  code;

   always_comb begin
      raw_in           = '0;
      raw_in[IDX_SCLK] = sclk;
      raw_in[IDX_SDI]  = sdi;
      raw_in[IDX_LD]   = ld;
   end

   sdac_sync #(.W(SYNC_W), .STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
   );

   assign s_sclk = syn[IDX_SCLK];
   assign s_sdi  = syn[IDX_SDI];
   assign s_ld   = syn[IDX_LD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sclk <= 1'b0;
         prev_ld   <= 1'b0;
      end else begin
         prev_sclk <= s_sclk;
         prev_ld   <= s_ld;
      end
   end

   assign sclk_rise = s_sclk & ~prev_sclk;
   assign ld_rise   = s_ld & ~prev_ld;
   assign shift_en  = sclk_rise & ~s_ld;

   sdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(s_sdi),
      .shreg(shreg), .sdo(sdo)
   );

   sdac_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_dec (
      .frame(shreg), .order_lsb(order_lsb), .sel(sel), .code(code)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic [DATA_W-1:0] lat;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                lat <= '0;
         else if (ld_rise && sel[g]) lat <= code;
      end
      assign chan_codes[g*DATA_W +: DATA_W] = lat;
   end
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
   parameter int NUM_CH = 10,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 10,
   localparam int FRAME_W = ADDR_W + DATA_W
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ld_rise,
   input logic                     shift_en,
   input logic                     ld_lvl,
   input logic [FRAME_W-1:0]       shreg,
   input logic                     sdo,
   input logic [NUM_CH*DATA_W-1:0] chan_codes
);
   logic                     was_rst;
   logic [NUM_CH*DATA_W-1:0] prev_codes;
   logic [NUM_CH-1:0]        changed;
   logic                     addr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         was_rst    <= 1'b1;
         prev_codes <= '0;
      end else begin
         was_rst    <= 1'b0;
         prev_codes <= chan_codes;
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chg
      assign changed[g] = prev_codes[g*DATA_W +: DATA_W] != chan_codes[g*DATA_W +: DATA_W];
   end

   assign addr_ok = (shreg[ADDR_W-1:0] >= ADDR_W'(1)) && (shreg[ADDR_W-1:0] <= ADDR_W'(NUM_CH));

   // R8
   rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      was_rst |-> chan_codes == '0);

   // R5
   one_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(changed) <= 1);

   // R5
   hold_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_rise |=> $stable(chan_codes));

   // R3
   bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rise && !addr_ok) |=> $stable(chan_codes));

   // R6
   ld_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lvl |=> $stable(shreg));

   // R7
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sdo));
endmodule

bind sdac_front sdac_front_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_rise(ld_rise), .shift_en(shift_en),
   .ld_lvl(s_ld), .shreg(shreg), .sdo(sdo), .chan_codes(chan_codes)
);

// File: tb/sim_sdac_front.sv
module sim_sdac_front;
   logic        clk = 1'b0;
   logic        rst_n, sclk, sdi, ld, order_lsb;
   logic        sdo10, sdo8;
   logic [99:0] codes10;
   logic [79:0] codes8;

   always #4 clk = ~clk;

   sdac_front u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .ld(ld),
      .order_lsb(order_lsb), .sdo(sdo10), .chan_codes(codes10)
   );

   sdac_front #(.NUM_CH(8)) u1 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .ld(ld),
      .order_lsb(order_lsb), .sdo(sdo8), .chan_codes(codes8)
   );

   typedef struct {
      logic [99:0] e10;
      logic [79:0] e8;
      logic        esdo;
      string       tag;
   } item_t;

   item_t      sb_q[$];
   event       smp;
   int         tests = 0;
   int         fails = 0;
   logic [9:0] m10 [1:10];
   logic [9:0] m8  [1:8];

   task automatic chk(input string tag, input logic [99:0] act, input logic [99:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per sample event and compares the ports
   initial begin
      forever begin
         item_t it;
         @(smp);
         it = sb_q.pop_front();
         chk({it.tag, " codes10"}, codes10, it.e10);
         chk({it.tag, " codes8"}, {20'd0, codes8}, {20'd0, it.e8});
         chk({it.tag, " sdo10"}, {99'd0, sdo10}, {99'd0, it.esdo});
         chk({it.tag, " sdo8"}, {99'd0, sdo8}, {99'd0, it.esdo});
      end
   end

   task automatic expect_now(input string tag, input logic esdo);
      item_t it;
      for (int i = 1; i <= 10; i++) it.e10[(i-1)*10 +: 10] = m10[i];
      for (int i = 1; i <= 8; i++)  it.e8[(i-1)*10 +: 10]  = m8[i];
      it.esdo = esdo;
      it.tag  = tag;
      sb_q.push_back(it);
      ->smp;
      @(negedge clk);
   endtask

   task automatic put_bit(input logic b);
      @(negedge clk) sdi = b;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic send_frame(input logic [3:0] a, input logic [9:0] c, input logic lsb);
      order_lsb = lsb;
      for (int i = 0; i < 4; i++) put_bit(a[i]);
      for (int i = 0; i < 10; i++) put_bit(lsb ? c[i] : c[9-i]);
   endtask

   task automatic strobe();
      @(negedge clk) ld = 1'b1;
      repeat (6) @(negedge clk);
      ld = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic model_write(input logic [3:0] a, input logic [9:0] c);
      if (a >= 1 && a <= 10) m10[a] = c;
      if (a >= 1 && a <= 8)  m8[a]  = c;
   endtask

   task automatic write(input logic [3:0] a, input logic [9:0] c, input logic lsb, input string tag);
      send_frame(a, c, lsb);
      strobe();
      model_write(a, c);
      expect_now(tag, a[0]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 1; i <= 10; i++) m10[i] = '0;
      for (int i = 1; i <= 8; i++)  m8[i]  = '0;
      rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; ld = 1'b0; order_lsb = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      expect_now("R8 reset state", 1'b0);

      write(4'd1,  10'h3FF, 1'b1, "R2 R4 lsb-first ch1");
      write(4'd10, 10'h155, 1'b1, "R2 ch10, R9 reserved in 8ch");
      write(4'd9,  10'h2AA, 1'b0, "R4 msb-first ch9, R9");
      write(4'd5,  10'h001, 1'b0, "R4 msb-first ch5");
      write(4'd2,  10'h200, 1'b1, "R4 lsb-first ch2");
      write(4'd8,  10'h0F0, 1'b0, "R2 ch8");
      write(4'd0,  10'h123, 1'b1, "R3 address 0");
      write(4'd11, 10'h321, 1'b1, "R3 address 11");
      write(4'd15, 10'h3C3, 1'b0, "R3 address 15");
      write(4'd3,  10'h2D2, 1'b1, "R1 first bit is address LSB");

      // R6: shift edges during the strobe are ignored, reload gives same word
      send_frame(4'd4, 10'h1A5, 1'b1);
      @(negedge clk) ld = 1'b1;
      repeat (6) @(negedge clk);
      put_bit(1'b1);
      put_bit(1'b1);
      put_bit(1'b1);
      ld = 1'b0;
      repeat (6) @(negedge clk);
      model_write(4'd4, 10'h1A5);
      expect_now("R6 clocks during load", 1'b0);
      strobe();
      expect_now("R6 R5 reload unchanged", 1'b0);

      // R7: cascade output walks through the held word
      write(4'd6, 10'h04C, 1'b1, "R7 sdo after word");
      put_bit(1'b0);
      chk("R7 sdo shows address bit1", {99'd0, sdo10}, {99'd0, 1'b1});
      put_bit(1'b0);
      chk("R7 sdo shows address bit2", {99'd0, sdo10}, {99'd0, 1'b1});
      put_bit(1'b0);
      chk("R7 sdo shows address bit3", {99'd0, sdo10}, {99'd0, 1'b0});

      // R8: reset in the middle of a word
      for (int i = 0; i < 7; i++) put_bit(1'b1);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      for (int i = 1; i <= 10; i++) m10[i] = '0;
      for (int i = 1; i <= 8; i++)  m8[i]  = '0;
      repeat (5) @(negedge clk);
      expect_now("R8 mid-word reset clears codes", 1'b0);
      strobe();
      expect_now("R8 partial word discarded", 1'b0);

      write(4'd7, 10'h08A, 1'b0, "R5 write after reset");

      repeat (4) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule